// File: doc/BRIEF.md
# BCD Calendar Clock Core

This core keeps the time of day and the calendar date as packed BCD counters: second, minute, hour (24-hour), day of week, date of month, month and a two-digit year. A one-cycle pulse on `tick_1hz` advances the counters by one second. Carries ripple from seconds up to the year. The date rolls over at the end of each month, and the month length accounts for 30-day months, 31-day months and February. February has 29 days when the year is a multiple of four.

Software does not see the live counters. It reads and writes eight byte-wide user registers at the top eight locations of a 15-bit byte address space. On every tick the core copies the new counter values into these registers. A control byte at the lowest of the eight locations holds two access flags and a calibration field. The READ flag freezes the copies so that a multi-byte read stays consistent while the counters keep running. The WRITE flag freezes the copies so that software can write a new time into them. Clearing the WRITE flag moves that time into the counters. Register reads are combinational from `addr`, and writes take effect on the clock edge where `wr_en` is high. The access port has no handshake: each access completes in one cycle and cannot be stalled.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the control byte reads 00h. The copies read second 00, minute 00, hour 00, day 01, date 01, month 01 and year 00.
- R2: Each tick adds one second. Second and minute wrap from 59 to 00 and carry into the next field. Hour wraps from 23 to 00 and carries into day and date. Without a tick or a load the counters hold.
- R3: Date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in all other months except 02. The wrap carries into the month.
- R4: In month 02 the date wraps after 29 when the year is a multiple of four (00 counts as one), and after 28 otherwise.
- R5: Day of week counts 1 to 7 and advances with the date, wrapping from 7 to 1. Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00.
- R6: A register is selected when addr[14:3] is all ones. addr[2:0] picks the register: 0 control, 1 second, 2 minute, 3 hour, 4 day, 5 date, 6 month, 7 year. Reads outside this window return 00h, and writes outside it change nothing.
- R7: When control bits 7 and 6 are both clear, a tick loads the copies with the new counter values on the same edge. A user write to a copy on that edge takes priority over the refresh.
- R8: While control bit 6 (READ flag) is set, the copies do not refresh but the counters keep advancing. After the flag clears, the next tick shows the time that kept running.
- R9: While control bit 7 (WRITE flag) is set, the copies hold the values written to them. Writing the control byte with bit 7 clear while bit 7 is set loads the counters from the copies. A tick on the same edge as that load is dropped.
- R10: Control bits 5:0 (sign in bit 5, magnitude in bits 4:0) are stored and read back, and they have no effect on counting or on refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 15 | Byte address; the top eight locations hold the clock registers |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |

## Verification
The bench puts the time at the last second before each month end and each year end, and checks the date after one tick. It covers 30-day and 31-day months, February in leap and non-leap years, year 00, and the 99 to 00 year wrap. A wrong month-length table or leap rule would show a day 29, 31 or 32 that should not exist, or would skip a valid one. The bench also checks that the copies freeze under the READ flag while time keeps running, that they hold written values under the WRITE flag, and that a tick on the edge where the WRITE flag clears is dropped. A design that gave the tick priority over the load would end up seconds off. Address decoding is checked with addresses whose low three bits match a register but whose upper bits fall outside the window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                        day: 8'h01, hour: 8'h00, minute: 8'h00,
                                        second: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur,
  output rtc_time_t nxt
);
  logic w_sec, w_min, w_hr, w_date, w_mon;

  always_comb begin
    nxt    = cur;
    w_sec  = cur.second >= 8'h59;
    w_min  = cur.minute >= 8'h59;
    w_hr   = cur.hour >= 8'h23;
    w_date = cur.date >= month_len(cur.month, cur.year);
    w_mon  = cur.month >= 8'h12;
    nxt.second = w_sec ? 8'h00 : bcd_inc(cur.second);
    if (w_sec) begin
      nxt.minute = w_min ? 8'h00 : bcd_inc(cur.minute);
      if (w_min) begin
        nxt.hour = w_hr ? 8'h00 : bcd_inc(cur.hour);
        if (w_hr) begin
          nxt.day  = (cur.day >= 8'h07) ? 8'h01 : cur.day + 8'h01;
          nxt.date = w_date ? 8'h01 : bcd_inc(cur.date);
          if (w_date) begin
            nxt.month = w_mon ? 8'h01 : bcd_inc(cur.month);
            if (w_mon) nxt.year = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= RESET_TIME;
    else if (load) cur <= load_val;
    else if (tick) cur <= nxt;
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load |=> $stable(cur));
  // R2
  sec_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load |=> cur.second != $past(cur.second));
  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val));
  // R5
  day_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && cur.day >= 8'h01 && cur.day <= 8'h07
    |=> cur.day >= 8'h01 && cur.day <= 8'h07);
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  rtc_time_t  nxt,
  input  logic       wr_stb,
  input  logic [2:0] wr_off,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_off,
  output logic [7:0] rd_byte,
  output rtc_time_t  copies,
  output logic [7:0] ctrl,
  output logic       load
);
  localparam int WFLAG = 7;
  localparam int RFLAG = 6;

  logic refresh;
  assign refresh = tick && !ctrl[WFLAG] && !ctrl[RFLAG];
  assign load    = wr_stb && (wr_off == 3'd0) && ctrl[WFLAG] && !wr_data[WFLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copies <= RESET_TIME;
      ctrl   <= 8'h00;
    end else begin
      if (refresh) copies <= nxt;
      if (wr_stb) begin
        case (wr_off)
          3'd0: ctrl          <= wr_data;
          3'd1: copies.second <= wr_data;
          3'd2: copies.minute <= wr_data;
          3'd3: copies.hour   <= wr_data;
          3'd4: copies.day    <= wr_data;
          3'd5: copies.date   <= wr_data;
          3'd6: copies.month  <= wr_data;
          default: copies.year <= wr_data;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_off)
      3'd0: rd_byte = ctrl;
      3'd1: rd_byte = copies.second;
      3'd2: rd_byte = copies.minute;
      3'd3: rd_byte = copies.hour;
      3'd4: rd_byte = copies.day;
      3'd5: rd_byte = copies.date;
      3'd6: rd_byte = copies.month;
      default: rd_byte = copies.year;
    endcase
  end

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[WFLAG] || ctrl[RFLAG]) && !wr_stb |=> $stable(copies));
  // R10
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_off == 3'd0 |=> ctrl == $past(wr_data));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  localparam int HI_W = ADDR_W - 3;

  logic       in_win, wr_stb, load;
  logic [7:0] rd_byte, ctrl;
  rtc_time_t  cur, nxt, copies;

  assign in_win  = &addr[ADDR_W-1:3];
  assign wr_stb  = wr_en && in_win;
  assign rd_data = in_win ? rd_byte : 8'h00;

  rtc_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load(load),
    .load_val(copies), .cur(cur), .nxt(nxt)
  );

  rtc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .nxt(nxt),
    .wr_stb(wr_stb), .wr_off(addr[2:0]), .wr_data(wr_data),
    .rd_off(addr[2:0]), .rd_byte(rd_byte), .copies(copies),
    .ctrl(ctrl), .load(load)
  );

  // R7
  refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz && ctrl[7:6] == 2'b00 && !wr_stb |=> copies == cur);
  // R6
  outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr[ADDR_W-1:3] != {HI_W{1'b1}}) |=> $stable(copies) && $stable(ctrl));
endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = 15'h0000;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [14:0] CTRL = 15'h7FF8, SEC = 15'h7FF9, MIN = 15'h7FFA,
    HR = 15'h7FFB, DOW = 15'h7FFC, DAT = 15'h7FFD, MON = 15'h7FFE, YR = 15'h7FFF;

  always #4 clk = ~clk;

  bcd_rtc_core dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
                    .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [14:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] y, mo, dt, dw, h, mi, s);
    wr(CTRL, 8'h80);
    wr(SEC, s); wr(MIN, mi); wr(HR, h); wr(DOW, dw); wr(DAT, dt); wr(MON, mo); wr(YR, y);
    wr(CTRL, 8'h00);
  endtask

  task automatic expect_time(input string req, input logic [7:0] y, mo, dt, dw, h, mi, s);
    rd_chk(req, SEC, s); rd_chk(req, MIN, mi); rd_chk(req, HR, h);
    rd_chk(req, DOW, dw); rd_chk(req, DAT, dt); rd_chk(req, MON, mo); rd_chk(req, YR, y);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", CTRL, 8'h00);
    expect_time("R1", 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_clock();
    tick();
    rd_chk("R2 R7 first tick", SEC, 8'h01);
    set_time(8'h30, 8'h06, 8'h10, 8'h03, 8'h12, 8'h59, 8'h59);
    tick();
    expect_time("R2 hour carry", 8'h30, 8'h06, 8'h10, 8'h03, 8'h13, 8'h00, 8'h00);
    set_time(8'h30, 8'h06, 8'h15, 8'h04, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R2 midnight", 8'h30, 8'h06, 8'h16, 8'h05, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_months();
    set_time(8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R3 30-day", 8'h21, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
    set_time(8'h21, 8'h01, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R3 31-day", 8'h21, 8'h02, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00);
    set_time(8'h21, 8'h11, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R3 november", 8'h21, 8'h12, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic leap_case(input logic [7:0] y, input bit leap);
    set_time(y, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk("R4 feb date", DAT, leap ? 8'h29 : 8'h01);
    rd_chk("R4 feb month", MON, leap ? 8'h02 : 8'h03);
  endtask

  task automatic t_leap();
    leap_case(8'h23, 1'b0);
    leap_case(8'h24, 1'b1);
    leap_case(8'h00, 1'b1);
    leap_case(8'h10, 1'b0);
    leap_case(8'h12, 1'b1);
    set_time(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R4 feb 29 end", 8'h24, 8'h03, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_year();
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    tick();
    expect_time("R5 year wrap", 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_read_flag();
    set_time(8'h05, 8'h03, 8'h10, 8'h02, 8'h08, 8'h30, 8'h15);
    tick();
    rd_chk("R8 start", SEC, 8'h16);
    wr(CTRL, 8'h40);
    tick(); tick(); tick();
    rd_chk("R8 frozen", SEC, 8'h16);
    rd_chk("R8 ctrl", CTRL, 8'h40);
    wr(CTRL, 8'h00);
    rd_chk("R8 after clear", SEC, 8'h16);
    tick();
    rd_chk("R8 kept running", SEC, 8'h20);
  endtask

  task automatic t_write_flag();
    set_time(8'h05, 8'h03, 8'h10, 8'h02, 8'h10, 8'h20, 8'h30);
    tick();
    wr(CTRL, 8'h80);
    wr(SEC, 8'h45); wr(MIN, 8'h10);
    tick();
    rd_chk("R9 held", SEC, 8'h45);
    @(negedge clk); addr = CTRL; wr_data = 8'h00; wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_1hz = 1'b0;
    rd_chk("R9 after load", SEC, 8'h45);
    tick();
    rd_chk("R9 tick dropped", SEC, 8'h46);
    rd_chk("R9 minute", MIN, 8'h10);
    rd_chk("R9 hour", HR, 8'h10);
  endtask

  task automatic t_calib();
    wr(CTRL, 8'h25);
    rd_chk("R10 readback", CTRL, 8'h25);
    tick();
    rd_chk("R10 no effect", SEC, 8'h47);
  endtask

  task automatic t_decode();
    rd_chk("R6 outside read", 15'h0001, 8'h00);
    wr(15'h0001, 8'h33);
    wr(15'h7FF1, 8'h33);
    rd_chk("R6 outside write", SEC, 8'h47);
    rd_chk("R6 near window", 15'h7FF0, 8'h00);
    rd_chk("R6 ctrl kept", CTRL, 8'h25);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clock();
    t_months();
    t_leap();
    t_year();
    t_read_flag();
    t_write_flag();
    t_calib();
    t_decode();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule